// File: doc/BRIEF.md
# Transmit Descriptor Ring Consumer

This block is the device side of a circular transmit queue. Host software places descriptors in a power-of-two ring in memory. It then writes the index one past its newest entry to a doorbell. The block keeps its own consumer index and works through the pending entries one at a time, in index order. For each entry it reads the descriptor, passes the buffer address and byte count to a data mover, and waits for the mover to finish. It then writes a completion status word back into that same ring slot. If the descriptor asks for an interrupt, it pulses an interrupt line.

Each ring entry is 128 bits. The lower 96 bits hold the fields software fills in, and the read port returns only those. The upper 32 bits hold the status word, which only the device writes. The doorbell is checked against the work still outstanding. A value that would move the producer behind the consumer is rejected and flagged. The consumer index is always visible on an output, so it can be mapped as a status register.

Top module: `txq_consumer`

## Requirements
- R1: While reset is high and in the first cycle after it, `cons_index` is 0 and `dsc_req`, `mv_req`, `irq` and `db_err` are all low.
- R2: When `cons_index` differs from the accepted producer index, the block issues a read (`dsc_req`=1, `dsc_we`=0) at `dsc_idx`=`cons_index`. It holds the request with a stable index until a one-cycle `dsc_ack`, which carries the descriptor on `dsc_rdata`.
- R3: The read data is laid out as buffer address in bits [63:0], length in [79:64] and flags in [95:80]. For a non-zero length the block drives `mv_addr`, `mv_len` and `mv_eop` (flag bit 0) from that data. It holds `mv_req` with stable fields until a one-cycle `mv_done`.
- R4: A descriptor whose length is zero produces no mover request. It goes straight to write-back.
- R5: Write-back is a request with `dsc_we`=1 at the same index. `dsc_wstatus` = {length[15:0], flags[15:1], 1'b1}, so bit 0 is the done bit. The request is held until `dsc_ack`.
- R6: The clock edge that accepts the write-back advances `cons_index` by one, modulo the ring size. Only that edge moves it.
- R7: `irq` is high for exactly the one cycle after an accepted write-back, and only when flag bit 1 of that descriptor is set.
- R8: Descriptors are handled one at a time in index order. The mover and descriptor requests are never active together. Nothing is requested while `cons_index` equals the producer index.
- R9: A doorbell value n is accepted when (n − cons_index) mod size ≥ (producer − cons_index) mod size. Otherwise the value is discarded, the producer index keeps its old value, and `db_err` is high for the following cycle.
- R10: A producer index of `cons_index` + size − 1 (a full ring) is accepted, and every one of those entries is processed.
- R11: A doorbell written in the same cycle as an accepted write-back is judged against the consumer index held before that write-back. When accepted, it takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| db_we | input | 1 | Doorbell write strobe |
| db_index | input | IDX_W | New producer index |
| db_err | output | 1 | Doorbell rejected (one cycle) |
| cons_index | output | IDX_W | Current consumer index |
| dsc_req | output | 1 | Descriptor port request |
| dsc_we | output | 1 | 1 = status write-back, 0 = descriptor read |
| dsc_idx | output | IDX_W | Ring slot addressed |
| dsc_wstatus | output | 32 | Status word to write |
| dsc_ack | input | 1 | Request accepted (one cycle) |
| dsc_rdata | input | 96 | Descriptor read data |
| mv_req | output | 1 | Mover request |
| mv_addr | output | 64 | Buffer address |
| mv_len | output | 16 | Buffer length in bytes |
| mv_eop | output | 1 | End-of-packet marker |
| mv_done | input | 1 | Mover finished (one cycle) |
| irq | output | 1 | Completion interrupt pulse |

## Verification
A doorbell can arrive on the same clock edge at which a write-back is accepted and the consumer index moves. At that edge the acceptance check must use the pre-advance index. The bench waits until it sees the memory model raise its write acknowledge, then writes the doorbell before the next edge, so both are sampled together. It confirms that no error is flagged and that processing continues until the consumer reaches the new producer value. The overrun case is provoked separately while work is outstanding: a value behind the current producer must raise `db_err` and leave the old producer target unchanged.

// File: rtl/txq_pkg.sv
package txq_pkg;

    localparam int FLG_EOP = 0;
    localparam int FLG_IRQ = 1;

    // Software-written part of a ring entry (status word lives above it)
    typedef struct packed {
        logic [15:0] flags;
        logic [15:0] len;
        logic [63:0] addr;
    } txq_desc_t;

    localparam int DESC_RD_W = $bits(txq_desc_t);

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_FETCH,
        ST_MOVE,
        ST_WB
    } txq_state_e;

    // Completion word: length, upper flag bits echoed, done in bit 0
    function automatic logic [31:0] make_status(input txq_desc_t d);
        return {d.len, d.flags[15:1], 1'b1};
    endfunction

endpackage

// File: rtl/txq_doorbell.sv
module txq_doorbell
    import txq_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             db_we,
    input  logic [IDX_W-1:0] db_index,
    input  logic [IDX_W-1:0] tail,
    output logic [IDX_W-1:0] head,
    output logic             db_err
);
    localparam int RING = 2 ** IDX_W;
    localparam logic [IDX_W-1:0] IDX_MASK = IDX_W'(RING - 1);

    logic [IDX_W-1:0] pend_now;
    logic [IDX_W-1:0] pend_new;
    logic             fits;

    always_comb begin
        pend_now = (head - tail) & IDX_MASK;
        pend_new = (db_index - tail) & IDX_MASK;
        fits     = (pend_new >= pend_now);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head   <= '0;
            db_err <= 1'b0;
        end else begin
            db_err <= db_we && !fits;
            if (db_we && fits) begin
                head <= db_index;
            end
        end
    end
endmodule

// File: rtl/txq_engine.sv
module txq_engine
    import txq_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [IDX_W-1:0]     head,
    output logic [IDX_W-1:0]     tail,
    output logic                 dsc_req,
    output logic                 dsc_we,
    output logic [IDX_W-1:0]     dsc_idx,
    output logic [31:0]          dsc_wstatus,
    input  logic                 dsc_ack,
    input  logic [DESC_RD_W-1:0] dsc_rdata,
    output logic                 mv_req,
    output logic [63:0]          mv_addr,
    output logic [15:0]          mv_len,
    output logic                 mv_eop,
    input  logic                 mv_done,
    output logic                 irq
);
    localparam int RING = 2 ** IDX_W;
    localparam logic [IDX_W-1:0] IDX_MASK = IDX_W'(RING - 1);

    txq_state_e state;
    txq_desc_t  cur;
    txq_desc_t  fetched;

    assign fetched = txq_desc_t'(dsc_rdata);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            tail  <= '0;
            cur   <= '0;
            irq   <= 1'b0;
        end else begin
            irq <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (tail != head) state <= ST_FETCH;
                end
                ST_FETCH: begin
                    if (dsc_ack) begin
                        cur   <= fetched;
                        state <= (fetched.len == '0) ? ST_WB : ST_MOVE;
                    end
                end
                ST_MOVE: begin
                    if (mv_done) state <= ST_WB;
                end
                ST_WB: begin
                    if (dsc_ack) begin
                        tail  <= (tail + 1'b1) & IDX_MASK;
                        irq   <= cur.flags[FLG_IRQ];
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        dsc_req     = (state == ST_FETCH) || (state == ST_WB);
        dsc_we      = (state == ST_WB);
        dsc_idx     = tail;
        dsc_wstatus = make_status(cur);
        mv_req      = (state == ST_MOVE);
        mv_addr     = cur.addr;
        mv_len      = cur.len;
        mv_eop      = cur.flags[FLG_EOP];
    end
endmodule

// File: rtl/txq_consumer.sv
module txq_consumer
    import txq_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 db_we,
    input  logic [IDX_W-1:0]     db_index,
    output logic                 db_err,
    output logic [IDX_W-1:0]     cons_index,
    output logic                 dsc_req,
    output logic                 dsc_we,
    output logic [IDX_W-1:0]     dsc_idx,
    output logic [31:0]          dsc_wstatus,
    input  logic                 dsc_ack,
    input  logic [DESC_RD_W-1:0] dsc_rdata,
    output logic                 mv_req,
    output logic [63:0]          mv_addr,
    output logic [15:0]          mv_len,
    output logic                 mv_eop,
    input  logic                 mv_done,
    output logic                 irq
);
    logic [IDX_W-1:0] head;
    logic [IDX_W-1:0] tail;

    txq_doorbell #(.IDX_W(IDX_W)) u_db (
        .clk      (clk),
        .rst      (rst),
        .db_we    (db_we),
        .db_index (db_index),
        .tail     (tail),
        .head     (head),
        .db_err   (db_err)
    );

    txq_engine #(.IDX_W(IDX_W)) u_eng (
        .clk         (clk),
        .rst         (rst),
        .head        (head),
        .tail        (tail),
        .dsc_req     (dsc_req),
        .dsc_we      (dsc_we),
        .dsc_idx     (dsc_idx),
        .dsc_wstatus (dsc_wstatus),
        .dsc_ack     (dsc_ack),
        .dsc_rdata   (dsc_rdata),
        .mv_req      (mv_req),
        .mv_addr     (mv_addr),
        .mv_len      (mv_len),
        .mv_eop      (mv_eop),
        .mv_done     (mv_done),
        .irq         (irq)
    );

    assign cons_index = tail;
endmodule

// File: rtl/txq_consumer_chk.sv
module txq_consumer_chk
    import txq_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 db_we,
    input logic [IDX_W-1:0]     db_index,
    input logic                 db_err,
    input logic [IDX_W-1:0]     cons_index,
    input logic                 dsc_req,
    input logic                 dsc_we,
    input logic [IDX_W-1:0]     dsc_idx,
    input logic [31:0]          dsc_wstatus,
    input logic                 dsc_ack,
    input logic [DESC_RD_W-1:0] dsc_rdata,
    input logic                 mv_req,
    input logic [63:0]          mv_addr,
    input logic [15:0]          mv_len,
    input logic                 mv_eop,
    input logic                 mv_done,
    input logic                 irq
);
    // R2
    dsc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        dsc_req && !dsc_ack |=> dsc_req && $stable(dsc_idx) && $stable(dsc_we));

    // R3
    mv_hold_chk: assert property (@(posedge clk) disable iff (rst)
        mv_req && !mv_done |=> mv_req && $stable(mv_addr) && $stable(mv_len) && $stable(mv_eop));

    // R5
    wb_stat_hold_chk: assert property (@(posedge clk) disable iff (rst)
        dsc_req && dsc_we && !dsc_ack |=> $stable(dsc_wstatus) && dsc_wstatus[0]);

    // R5
    slot_match_chk: assert property (@(posedge clk) disable iff (rst)
        dsc_req |-> dsc_idx == cons_index);

    // R6
    cons_step_chk: assert property (@(posedge clk) disable iff (rst)
        cons_index != $past(cons_index) |->
            cons_index == IDX_W'($past(cons_index) + 1'b1) && $past(dsc_req && dsc_we && dsc_ack));

    // R7
    irq_src_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(dsc_req && dsc_we && dsc_ack));

    // R8
    one_req_chk: assert property (@(posedge clk) disable iff (rst)
        !(dsc_req && mv_req));

    // R9
    err_src_chk: assert property (@(posedge clk) disable iff (rst)
        db_err |-> $past(db_we));
endmodule

bind txq_consumer txq_consumer_chk #(.IDX_W(IDX_W)) u_chk (.*);

// File: tb/txq_consumer_test.sv
module txq_consumer_test;

    localparam int IW = 3;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            db_we = 1'b0;
    logic [IW-1:0]   db_index = '0;
    logic            db_err;
    logic [IW-1:0]   cons_index;
    logic            dsc_req;
    logic            dsc_we;
    logic [IW-1:0]   dsc_idx;
    logic [31:0]     dsc_wstatus;
    logic            dsc_ack = 1'b0;
    logic [95:0]     dsc_rdata = '0;
    logic            mv_req;
    logic [63:0]     mv_addr;
    logic [15:0]     mv_len;
    logic            mv_eop;
    logic            mv_done = 1'b0;
    logic            irq;

    always #5 clk = ~clk;

    txq_consumer #(.IDX_W(IW)) uut (.*);

    int n_checks = 0;
    int n_fail   = 0;
    int n_moves  = 0;
    int n_writes = 0;
    int n_irqs   = 0;
    bit finished = 0;
    logic [IW-1:0] exp_ptr = '0;

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] e_len(input logic [IW-1:0] i);
        return (i == 3'd5) ? 16'd0 : 16'h40 + 16'(i) * 16'd3;
    endfunction

    function automatic logic [15:0] e_flags(input logic [IW-1:0] i);
        return {1'b0, i, 10'h0, (i == 3'd2 || i == 3'd6), i[0]};
    endfunction

    function automatic logic [63:0] e_addr(input logic [IW-1:0] i);
        return 64'h0000_0012_0000_0000 + {49'b0, i, 12'h0};
    endfunction

    // Descriptor memory model: ack on the third cycle of a request
    initial begin
        int  cnt = 0;
        bit  last_wr = 0;
        bit  last_irq = 0;
        forever begin
            @(negedge clk);
            if (dsc_ack) begin
                dsc_ack = 1'b0;
                cnt = 0;
                if (last_wr) begin
                    chk(irq == last_irq, "R7 irq after write-back", 64'(irq), 64'(last_irq));
                    chk(cons_index == exp_ptr, "R6 consumer advance", 64'(cons_index), 64'(exp_ptr));
                    if (irq) n_irqs++;
                end
                last_wr = 0;
            end else if (dsc_req) begin
                if (cnt == 2) begin
                    cnt = 0;
                    dsc_ack = 1'b1;
                    if (dsc_we) begin
                        chk(dsc_idx == exp_ptr, "R5 write-back slot", 64'(dsc_idx), 64'(exp_ptr));
                        chk(dsc_wstatus == {e_len(exp_ptr), e_flags(exp_ptr)[15:1], 1'b1},
                            "R5 status word", 64'(dsc_wstatus),
                            64'({e_len(exp_ptr), e_flags(exp_ptr)[15:1], 1'b1}));
                        last_irq = e_flags(exp_ptr)[1];
                        last_wr = 1;
                        exp_ptr = exp_ptr + 1'b1;
                        n_writes++;
                    end else begin
                        chk(dsc_idx == exp_ptr, "R2 fetch slot", 64'(dsc_idx), 64'(exp_ptr));
                        dsc_rdata = {e_flags(exp_ptr), e_len(exp_ptr), e_addr(exp_ptr)};
                    end
                end else begin
                    cnt++;
                end
            end
        end
    end

    // Data mover model: done on the fourth cycle of a request
    initial begin
        int cnt = 0;
        forever begin
            @(negedge clk);
            if (mv_done) begin
                mv_done = 1'b0;
                cnt = 0;
            end else if (mv_req) begin
                if (cnt == 0) begin
                    chk(e_len(exp_ptr) != 16'd0, "R4 no move for zero length", 64'(mv_len), 64'd0);
                    chk(mv_addr == e_addr(exp_ptr), "R3 mover address", mv_addr, e_addr(exp_ptr));
                    chk(mv_len == e_len(exp_ptr), "R3 mover length", 64'(mv_len), 64'(e_len(exp_ptr)));
                    chk(mv_eop == e_flags(exp_ptr)[0], "R3 mover eop", 64'(mv_eop), 64'(e_flags(exp_ptr)[0]));
                end
                if (cnt == 3) begin
                    mv_done = 1'b1;
                    cnt = 0;
                    n_moves++;
                end else begin
                    cnt++;
                end
            end
        end
    end

    task automatic ring_db(input logic [IW-1:0] v, output logic err);
        @(negedge clk); #1;
        db_we = 1'b1;
        db_index = v;
        @(negedge clk); #1;
        err = db_err;
        db_we = 1'b0;
    endtask

    task automatic wait_idle(input logic [IW-1:0] target);
        int quiet = 0;
        for (int k = 0; k < 3000; k++) begin
            @(negedge clk); #1;
            if (cons_index == target && !dsc_req && !mv_req) quiet++;
            else quiet = 0;
            if (quiet == 6) break;
        end
    endtask

    typedef struct packed {
        logic [IW-1:0] db;
        logic [IW-1:0] cons;
        logic [3:0]    moves;
        logic [3:0]    writes;
        logic [1:0]    irqs;
    } vec_t;

    // Vector 4 fills the ring to size-1 entries (R10); vector 2 is an idle no-op (R8)
    localparam vec_t VECS [4] = '{
        '{3'd3, 3'd3, 4'd3, 4'd3, 2'd1},
        '{3'd3, 3'd3, 4'd0, 4'd0, 2'd0},
        '{3'd1, 3'd1, 4'd5, 4'd6, 2'd1},
        '{3'd0, 3'd0, 4'd6, 4'd7, 2'd2}
    };

    initial begin
        logic err;
        int m0, w0, i0;

        // R1 reset state
        repeat (4) @(negedge clk);
        #1;
        chk(cons_index == '0 && !dsc_req && !mv_req && !irq && !db_err,
            "R1 outputs in reset", 64'({cons_index, dsc_req, mv_req, irq, db_err}), 64'd0);
        rst = 1'b0;
        @(negedge clk); #1;
        chk(cons_index == '0, "R1 consumer index after reset", 64'(cons_index), 64'd0);
        chk(!dsc_req && !mv_req, "R1 no request after reset", 64'({dsc_req, mv_req}), 64'd0);
        chk(!irq && !db_err, "R1 irq and error low", 64'({irq, db_err}), 64'd0);

        for (int v = 0; v < 4; v++) begin
            m0 = n_moves; w0 = n_writes; i0 = n_irqs;
            ring_db(VECS[v].db, err);
            chk(err == 1'b0, "R9 valid doorbell not flagged", 64'(err), 64'd0);
            wait_idle(VECS[v].cons);
            chk(cons_index == VECS[v].cons, "R6/R8/R10 final consumer index", 64'(cons_index), 64'(VECS[v].cons));
            chk(n_writes - w0 == int'(VECS[v].writes), "R8/R10 descriptors completed",
                64'(n_writes - w0), 64'(VECS[v].writes));
            chk(n_moves - m0 == int'(VECS[v].moves), "R3/R4 mover transfers",
                64'(n_moves - m0), 64'(VECS[v].moves));
            chk(n_irqs - i0 == int'(VECS[v].irqs), "R7 interrupt count",
                64'(n_irqs - i0), 64'(VECS[v].irqs));
        end

        // R9 overrun while four entries are outstanding
        w0 = n_writes;
        ring_db(3'd4, err);
        chk(err == 1'b0, "R9 ahead doorbell accepted", 64'(err), 64'd0);
        ring_db(3'd2, err);
        chk(err == 1'b1, "R9 overrun flagged", 64'(err), 64'd1);
        @(negedge clk); #1;
        chk(db_err == 1'b0, "R9 error is a single pulse", 64'(db_err), 64'd0);
        wait_idle(3'd4);
        chk(cons_index == 3'd4, "R9 producer kept after reject", 64'(cons_index), 64'd4);
        chk(n_writes - w0 == 4, "R9 entries after reject", 64'(n_writes - w0), 64'd4);

        // R11 doorbell on the write-back acceptance edge
        w0 = n_writes;
        ring_db(3'd6, err);
        for (int k = 0; k < 200; k++) begin
            @(negedge clk); #1;
            if (dsc_ack && dsc_we) break;
        end
        db_we = 1'b1;
        db_index = 3'd1;
        @(negedge clk); #1;
        db_we = 1'b0;
        chk(db_err == 1'b0, "R11 same-edge doorbell accepted", 64'(db_err), 64'd0);
        wait_idle(3'd1);
        chk(cons_index == 3'd1, "R11 consumer reaches new producer", 64'(cons_index), 64'd1);
        chk(n_writes - w0 == 5, "R11 entries processed", 64'(n_writes - w0), 64'd5);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule